// File: doc/BRIEF.md
# Dual-Mode Noise-Shaping Modulator for a 3-Bit DAC

The block turns a stream of 14-bit signed samples, one per clock, into a stream of 3-bit two's-complement codes, one per clock, for a multi-level DAC. Quantization noise is pushed out of the band of interest by a second-order error-feedback loop. A single mode pin chooses where that band sits. With highpass shaping the signal lives near half the clock rate and the noise transfer function is (1 + z^-1)^2. With bandpass shaping the signal lives near one quarter and three quarters of the clock rate and the noise transfer function is 1 + z^-2.

The arithmetic is not a word-wide adder in a loop. Each bit position is a slice holding two 1-bit subtract cells, with a register between neighbouring slices on both borrow chains. Sample bits enter the array skewed, the low residual bits come out first and feed the next samples' slices on time, and the upper bits are re-aligned before saturation. Latency is therefore fixed and independent of the data. A mode change resets the stored error to zero for the sample that sees the new mode.

Top module: `nshape_dsm`

## Requirements
- R1: A sample is taken from `din` on every rising edge after reset release, and the code for the sample taken at edge n is on `code` right after edge n+17; codes are two's complement, -4 to +3.
- R2: With `mode_bp` = 0 (highpass), w = x + 4096 - 2*r1 - r2, the code is floor(w/2048) and the stored residual of this sample is w mod 2048, where r1 and r2 are the residuals of the previous and second-previous sample; results match this bit for bit.
- R3: With `mode_bp` = 1 (bandpass), w = x + 2048 - r2 with the same code and residual rules; results match bit for bit.
- R4: When floor(w/2048) exceeds +3 the code is +3, and when it is below -4 the code is -4; the residual is still w mod 2048.
- R5: When `mode_bp` differs from the value taken with the previous sample (0 is assumed before the first sample after reset), both stored residuals are treated as 1024 (zero error) for that sample; its code is therefore round(x/2048) = floor((x+1024)/2048), saturated as in R4.
- R6: `code` is 0 while reset is asserted and stays 0 until the result of the first sample arrives.
- R7: For every sample, |code*2048 - x| is at most 4096 in highpass mode and at most 2048 in bandpass mode.
- R8: For a constant input that does not drive the code into saturation, the mean of code*2048 - x over any window lies within 2048 codes-units times 2 (highpass) or times 1 (bandpass), i.e. within two or one output steps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_bp | input | 1 | Shaping select: 0 highpass, 1 bandpass; sampled with each input word |
| din | input | 14 | Signed input sample |
| code | output | 3 | Signed output code for the DAC |

## Verification
The bound and rounding properties assume that `din` and `mode_bp` are settled at each rising edge and change only between edges, so that the checker's own delay line of inputs lines up with the block's skewed pipeline; the bench drives both on falling edges only. They also take the input word to be any 14-bit value including the extremes, which is why the bounds are derived for saturated codes as well. The averaging check additionally assumes constants far enough from full scale that no code clips, and the stimulus picks its constant levels inside that range.

// File: rtl/nshape_dsm.sv
module nshape_dsm #(
  parameter int DIN_W  = 14,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_bp,
  input  logic [DIN_W-1:0]  din,
  output logic [CODE_W-1:0] code
);
  localparam int W  = DIN_W + 2;
  localparam int FB = DIN_W - CODE_W;
  localparam int QW = W - FB;
  localparam logic [FB-1:0] HALF = {1'b1, {(FB-1){1'b0}}};
  localparam logic signed [QW-1:0] QMAX = QW'(2**(CODE_W-1) - 1);
  localparam logic signed [QW-1:0] QMIN = QW'(-(2**(CODE_W-1)));

  logic [W-1:0]  dinx;
  logic [W-1:0]  xk, a, b, t, w;
  logic [W-1:0]  mode_p;
  logic [FB-1:0] clr_p;
  logic [W:0]    vld_p;
  logic [W-1:0]  bor1_q, bor2_q;
  logic [W-2:0]  bo1, bo2;
  logic [FB-1:0] p, ppe;
  logic [FB:1]   pp_q;
  logic [QW-1:0] hi;
  logic signed [QW-1:0] his;
  logic [CODE_W-1:0] qsat;

  assign dinx = {{(W-DIN_W){din[DIN_W-1]}}, din};

  // one slice per bit: two 1-bit subtract cells, borrows registered between slices
  for (genvar k = 0; k < W; k++) begin : g_slice
    if (k == 0) begin : g_x0
      logic xq;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) xq <= 1'b0;
        else        xq <= dinx[0];
      assign xk[k] = xq;
    end else begin : g_xn
      logic [k:0] xq;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) xq <= '0;
        else        xq <= {xq[k-1:0], dinx[k]};
      assign xk[k] = xq[k];
    end

    if (k == 0) begin : g_a0
      assign a[k] = 1'b0;
    end else if (k < FB) begin : g_alo
      assign a[k] = ~mode_p[k] & pp_q[k];
    end else if (k == FB) begin : g_amid
      assign a[k] = mode_p[k] | pp_q[k];
    end else begin : g_ahi
      assign a[k] = 1'b1;
    end

    assign t[k] = xk[k] ^ a[k] ^ bor1_q[k];
    assign w[k] = t[k] ^ b[k] ^ bor2_q[k];

    if (k < W - 1) begin : g_bor
      assign bo1[k] = (~xk[k] & (a[k] | bor1_q[k])) | (a[k] & bor1_q[k]);
      assign bo2[k] = (~t[k]  & (b[k] | bor2_q[k])) | (b[k] & bor2_q[k]);
    end

    if (k < FB) begin : g_err
      logic rq, rqq;
      assign p[k]   = clr_p[k] ? HALF[k] : rq;
      assign ppe[k] = clr_p[k] ? HALF[k] : rqq;
      assign b[k]   = ppe[k];
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          rq  <= HALF[k];
          rqq <= HALF[k];
        end else if (vld_p[k]) begin
          rq  <= w[k];
          rqq <= p[k];
        end
    end else begin : g_out
      localparam int D = W - k;
      logic [D-1:0] ch;
      assign b[k] = 1'b0;
      if (D == 1) begin : g_d1
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) ch <= '0;
          else        ch <= w[k];
      end else begin : g_dn
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) ch <= '0;
          else        ch <= {ch[D-2:0], w[k]};
      end
      assign hi[k-FB] = ch[D-1];
    end
  end

  assign his  = $signed(hi);
  assign qsat = (his > QMAX) ? QMAX[CODE_W-1:0] :
                (his < QMIN) ? QMIN[CODE_W-1:0] : his[CODE_W-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode_p <= '0;
      clr_p  <= '0;
      vld_p  <= '0;
      bor1_q <= '0;
      bor2_q <= '0;
      pp_q   <= '0;
      code   <= '0;
    end else begin
      mode_p <= {mode_p[W-2:0], mode_bp};
      clr_p  <= {clr_p[FB-2:0], mode_bp ^ mode_p[0]};
      vld_p  <= {vld_p[W-1:0], 1'b1};
      bor1_q <= {bo1, 1'b0};
      bor2_q <= {bo2, 1'b0};
      pp_q   <= p;
      if (vld_p[W]) code <= qsat;
    end
endmodule

// File: rtl/nshape_dsm_chk.sv
module nshape_dsm_chk #(
  parameter int DIN_W  = 14,
  parameter int CODE_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_bp,
  input logic [DIN_W-1:0]  din,
  input logic [CODE_W-1:0] code
);
  localparam int FB   = DIN_W - CODE_W;
  localparam int LAT  = DIN_W + 3;
  localparam int QMAX = 2**(CODE_W-1) - 1;

  logic [LAT:0] dv, dm, dc;
  logic [DIN_W-1:0] dx [LAT+1];
  logic last_m;
  int xv, cv, diff, rnd;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dv <= '0; dm <= '0; dc <= '0; last_m <= 1'b0;
    end else begin
      dv <= {dv[LAT-1:0], 1'b1};
      dm <= {dm[LAT-1:0], mode_bp};
      dc <= {dc[LAT-1:0], mode_bp ^ last_m};
      last_m <= mode_bp;
    end

  always_ff @(posedge clk) begin
    dx[0] <= din;
    for (int i = 1; i <= LAT; i++) dx[i] <= dx[i-1];
  end

  always_comb begin
    xv   = int'($signed(dx[LAT]));
    cv   = int'($signed(code));
    diff = cv * (2**FB) - xv;
    rnd  = (xv + 2**(FB-1)) >>> FB;
    if (rnd > QMAX)      rnd = QMAX;
    if (rnd < -QMAX - 1) rnd = -QMAX - 1;
  end

  assert_warmup_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !dv[LAT] |-> code == '0);
  assert_clear_round_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dv[LAT] && dc[LAT] |-> cv == rnd);
  assert_hp_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dv[LAT] && !dm[LAT] |-> (diff <= 2**(FB+1)) && (diff >= -(2**(FB+1))));
  assert_bp_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dv[LAT] && dm[LAT] |-> (diff <= 2**FB) && (diff >= -(2**FB)));
endmodule

bind nshape_dsm nshape_dsm_chk #(.DIN_W(DIN_W), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_bp(mode_bp), .din(din), .code(code));

// File: tb/test_nshape_dsm.sv
module test_nshape_dsm;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_bp = 1'b0;
  logic [13:0] din = '0;
  logic [2:0] code;

  nshape_dsm i_nshape_dsm (.clk(clk), .rst_n(rst_n), .mode_bp(mode_bp), .din(din), .code(code));

  always #4 clk = ~clk;

  typedef struct {int c; int x; bit m; bit clr; bit sat; int tag;} exp_t;
  exp_t q[$];
  int nchk = 0, nfail = 0, cap = 0, r1, r2;
  bit lastm, done = 0;
  longint sum1 = 0, sum2 = 0;
  int n1 = 0, n2 = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic compare(input exp_t e);
    int a, d;
    string req;
    a = int'($signed(code));
    req = e.clr ? "R5 clear-round (R1 latency)" : e.sat ? "R4 saturate (R1 latency)" :
          e.m ? "R3 bandpass exact (R1 latency)" : "R2 highpass exact (R1 latency)";
    chk(a == e.c, req, a, e.c);
    d = a * 2048 - e.x;
    if (e.m) chk(d <= 2048 && d >= -2048, "R7 bandpass bound", d, 2048);
    else     chk(d <= 4096 && d >= -4096, "R7 highpass bound", d, 4096);
    if (e.tag == 1) begin sum1 += d; n1++; end
    if (e.tag == 2) begin sum2 += d; n2++; end
  endtask

  task automatic step(input int x, input bit m, input int tag);
    exp_t e;
    int w, qv;
    e.clr = (m != lastm);
    lastm = m;
    if (e.clr) begin r1 = 1024; r2 = 1024; end
    w  = m ? x + 2048 - r2 : x + 4096 - 2 * r1 - r2;
    qv = w >>> 11;
    e.sat = 1'b0;
    if (qv > 3)  begin qv = 3;  e.sat = 1'b1; end
    if (qv < -4) begin qv = -4; e.sat = 1'b1; end
    r2 = r1;
    r1 = w & 2047;
    e.c = qv; e.x = x; e.m = m; e.tag = tag;
    q.push_back(e);
    din = 14'(x);
    mode_bp = m;
    @(negedge clk);
    cap++;
    if (cap >= 18) compare(q.pop_front());
    else chk(code == 3'd0, "R6 zero before first result", int'($signed(code)), 0);
  endtask

  function automatic int rnd14();
    return int'($urandom_range(16383)) - 8192;
  endfunction

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cap, 0);
      summary();
      $finish;
    end
  end

  initial begin
    din = 14'h1abc;
    repeat (3) begin
      @(negedge clk);
      chk(code == 3'd0, "R6 reset value", int'($signed(code)), 0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    lastm = 1'b0; r1 = 1024; r2 = 1024;
    step(8191, 1'b0, 0);
    for (int i = 0; i < 300; i++) step(rnd14(), 1'b0, 0);
    for (int i = 0; i < 300; i++) step(rnd14(), 1'b1, 0);
    for (int i = 0; i < 256; i++) step(3000, 1'b1, 1);
    for (int i = 0; i < 256; i++) step(-2500, 1'b0, 2);
    for (int i = 0; i < 20; i++) step(8191, 1'b0, 0);
    for (int i = 0; i < 20; i++) step(-8192, 1'b0, 0);
    for (int i = 0; i < 20; i++) step(8191, 1'b1, 0);
    for (int i = 0; i < 20; i++) step(-8192, 1'b1, 0);
    for (int i = 0; i < 120; i++) step(rnd14(), 1'((i / 3) % 2), 0);
    for (int i = 0; i < 20; i++) step(0, 1'b1, 0);
    chk(n1 == 256 && (sum1 <= 2048 * n1) && (sum1 >= -2048 * n1),
        "R8 bandpass mean", sum1, 2048 * n1);
    chk(n2 == 256 && (sum2 <= 4096 * n2) && (sum2 >= -4096 * n2),
        "R8 highpass mean", sum2, 4096 * n2);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule